// File: doc/BRIEF.md
# One-Wire Identity Fetch and MAC Builder

This block runs once per start strobe and pulls a block of identification memory out of a single device on a one-wire bus, then turns it into a 48-bit Ethernet station address. It does not time the bus itself. Instead it hands byte-level requests (bus reset, write byte, read byte) to a separate bus engine and waits for that engine's completion pulse before it moves on.

After a reset that finds a device, the block skips device addressing and sends the memory-read command with a zero start address. It then reads one check byte, which it discards, and fills a 28-byte buffer. A 16-character ASCII signature, held as a parameter, must appear in buffer bytes 11 to 26. When it does, the address is a fixed three-byte prefix followed by buffer bytes 7, 6 and 5, in that order. In every other case the block produces a fallback address and an error code.

Top module: `ow_id_fetch`

## Requirements
- R1: While reset is held and afterwards until the first start, `req_valid`, `done`, `mac_addr` and `err_code` are all zero.
- R2: In the idle state, `start` issues a bus-reset request (`req_op` = 0). Any `start` that arrives while a fetch is running has no effect: it causes no extra request, and once `done` has pulsed no new request appears.
- R3: If the reset reply reports no presence, no further request is issued. `done` pulses one cycle after that reply, with `err_code` = 1 and `mac_addr` = 00:E0:EE:FF:FF:FF.
- R4: After presence, four write requests (`req_op` = 1) follow in this order, carrying 0xCC, 0xF0, 0x00 and 0x00.
- R5: Twenty-nine read requests (`req_op` = 2) follow. The first reply is discarded. The remaining 28 replies fill buffer bytes 0 to 27 in order.
- R6: Each request holds `req_valid`, `req_op` and `req_data` steady until the cycle in which `bus_done` is high. The next request is presented in the following cycle.
- R7: If buffer bytes 11 to 26 equal the signature, with its first character at byte 11 (default "NODE-ID-MAC48-v1"), then `err_code` = 0 and `mac_addr` = {8'h00, 8'hE0, 8'hEE, buffer[7], buffer[6], buffer[5]}, most significant byte first.
- R8: On any signature mismatch with a device present, `err_code` = 2 and `mac_addr` = 00:E0:EE:FF:FF:FF.
- R9: `done` is high for exactly one cycle per fetch. In that same cycle `mac_addr` and `err_code` show their final values, and they keep those values until the next `done`.
- R10: The signature compare checks one character per cycle and stops at the first mismatch. Counting from the last read reply, `done` rises k+2 cycles later for a mismatch at character k, and 17 cycles later for a full match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch (acted on only when idle) |
| req_valid | output | 1 | Request to the bus engine is pending |
| req_op | output | 2 | 0 bus reset, 1 write byte, 2 read byte |
| req_data | output | 8 | Byte to write |
| bus_done | input | 1 | One-cycle completion of the pending request |
| bus_presence | input | 1 | Presence result, valid with `bus_done` on a reset |
| bus_rdata | input | 8 | Read byte, valid with `bus_done` on a read |
| mac_addr | output | 48 | Assembled or fallback station address |
| err_code | output | 2 | 0 ok, 1 no device, 2 bad signature |
| done | output | 1 | One-cycle pulse when the result is final |

## Verification
Two events can land in the same cycle: a fresh `start` and a `bus_done` that advances the sequence. The engine model raises `start` in the exact cycle of a chosen completion, and it also raises `start` during random wait cycles. The run is judged correct when the logged request stream still holds exactly one reset, four writes and 29 reads, when only one `done` pulse occurs, and when no request follows it. Random buffers, planted mismatch positions and an absent device are compared against bench functions for the address, the error code and the compare latency.

// File: rtl/ow_id_fetch.sv
module ow_id_fetch #(
  parameter int NBYTES = 28,
  parameter int SIG_OFS = 11,
  parameter int SIG_LEN = 16,
  parameter logic [8*SIG_LEN-1:0] SIGNATURE = "NODE-ID-MAC48-v1",
  parameter logic [23:0] PREFIX = 24'h00E0EE,
  parameter int MAC_IDX = 5,
  parameter logic [7:0] CMD_SKIP = 8'hCC,
  parameter logic [7:0] CMD_READ = 8'hF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        req_valid,
  output logic [1:0]  req_op,
  output logic [7:0]  req_data,
  input  logic        bus_done,
  input  logic        bus_presence,
  input  logic [7:0]  bus_rdata,
  output logic [47:0] mac_addr,
  output logic [1:0]  err_code,
  output logic        done
);
  localparam int CW = $clog2(NBYTES + 2);
  localparam int IW = $clog2(NBYTES);
  localparam int KW = $clog2(SIG_LEN);
  localparam logic [1:0] OP_RST = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [1:0] E_OK = 2'd0, E_ABSENT = 2'd1, E_BADSIG = 2'd2;
  localparam logic [47:0] FALLBACK = {PREFIX, 24'hFFFFFF};

  typedef enum logic [2:0] {S_IDLE, S_RST, S_WR, S_RD, S_CMP} state_t;
  state_t st;
  logic [CW-1:0] cnt;
  logic [7:0] mem [NBYTES];

  logic [KW-1:0] cmp_k;
  logic [IW-1:0] cmp_idx;
  logic [7:0] sig_chr;
  assign cmp_k   = (int'(cnt) < SIG_LEN) ? KW'(cnt) : '0;
  assign cmp_idx = IW'(SIG_OFS) + IW'(cmp_k);
  assign sig_chr = SIGNATURE[8*(SIG_LEN-1-int'(cmp_k)) +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      req_valid <= 1'b0;
      req_op <= OP_RST;
      req_data <= '0;
      mac_addr <= '0;
      err_code <= E_OK;
      done <= 1'b0;
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
          cnt <= '0;
          req_valid <= 1'b1;
          req_op <= OP_RST;
          req_data <= '0;
          st <= S_RST;
        end
        S_RST: if (bus_done) begin
          if (bus_presence) begin
            req_op <= OP_WR;
            req_data <= CMD_SKIP;
            cnt <= '0;
            st <= S_WR;
          end else begin
            req_valid <= 1'b0;
            mac_addr <= FALLBACK;
            err_code <= E_ABSENT;
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_WR: if (bus_done) begin
          if (cnt == CW'(3)) begin
            req_op <= OP_RD;
            req_data <= '0;
            cnt <= '0;
            st <= S_RD;
          end else begin
            req_data <= (cnt == '0) ? CMD_READ : 8'h00;
            cnt <= cnt + 1'b1;
          end
        end
        S_RD: if (bus_done) begin
          if (cnt != '0) mem[IW'(cnt - 1'b1)] <= bus_rdata;
          if (cnt == CW'(NBYTES)) begin
            req_valid <= 1'b0;
            cnt <= '0;
            st <= S_CMP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CMP: begin
          if (mem[cmp_idx] != sig_chr) begin
            mac_addr <= FALLBACK;
            err_code <= E_BADSIG;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (cnt == CW'(SIG_LEN - 1)) begin
            mac_addr <= {PREFIX, mem[MAC_IDX+2], mem[MAC_IDX+1], mem[MAC_IDX]};
            err_code <= E_OK;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(mac_addr)) && (done || $stable(err_code)));
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_done) |=> req_valid && $stable(req_op) && $stable(req_data));
  p_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mac_addr[47:24] == PREFIX);
  p_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != E_OK) |-> mac_addr[23:0] == 24'hFFFFFF);
  p_no_req_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  p_err_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'd3);
endmodule

// File: tb/ow_id_fetch_tb.sv
module ow_id_fetch_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] SIG = "NODE-ID-MAC48-v1";

  logic clk = 1'b0, rst_n = 1'b0;
  logic main_start = 1'b0, eng_start = 1'b0, start;
  logic req_valid, done, bus_done, bus_presence;
  logic [1:0] req_op, err_code;
  logic [7:0] req_data, bus_rdata;
  logic [47:0] mac_addr;
  assign start = main_start | eng_start;

  ow_id_fetch u_dut (.clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
    .req_op(req_op), .req_data(req_data), .bus_done(bus_done), .bus_presence(bus_presence),
    .bus_rdata(bus_rdata), .mac_addr(mac_addr), .err_code(err_code), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit dev_present, noise;
  logic [7:0] dev [29];
  logic [1:0] log_op [64];
  logic [7:0] log_dat [64];
  int n_log, rd_i, start_at, last_bd;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int first_mis();
    for (int k = 0; k < 16; k++)
      if (dev[1+11+k] != SIG[8*(15-k) +: 8]) return k;
    return 16;
  endfunction

  function automatic logic [47:0] exp_mac();
    if (!dev_present || first_mis() != 16) return 48'h00E0EEFFFFFF;
    return {24'h00E0EE, dev[8], dev[7], dev[6]};
  endfunction

  function automatic logic [1:0] exp_err();
    if (!dev_present) return 2'd1;
    return (first_mis() == 16) ? 2'd0 : 2'd2;
  endfunction

  function automatic int exp_lat();
    if (!dev_present) return 1;
    return (first_mis() == 16) ? 17 : first_mis() + 2;
  endfunction

  initial begin
    bus_done = 1'b0; bus_presence = 1'b0; bus_rdata = '0;
    forever begin
      if (!req_valid) @(negedge clk);
      else begin
        int dly;
        logic [1:0] op;
        op = req_op;
        if (n_log < 64) begin log_op[n_log] = req_op; log_dat[n_log] = req_data; end
        n_log++;
        dly = $urandom_range(0, 3);
        repeat (dly) begin eng_start = noise; @(negedge clk); eng_start = 1'b0; end
        bus_done = 1'b1;
        eng_start = (n_log - 1 == start_at);
        if (op == 2'd0) bus_presence = dev_present;
        if (op == 2'd2) begin bus_rdata = dev[rd_i]; rd_i++; end
        last_bd = cyc;
        @(negedge clk);
        bus_done = 1'b0; eng_start = 1'b0;
      end
    end
  end

  task automatic run_fetch(string name);
    int n, lat;
    logic [47:0] m;
    logic [1:0] e;
    n_log = 0; rd_i = 0;
    @(negedge clk); main_start = 1'b1;
    @(negedge clk); main_start = 1'b0;
    chk(n_log == 1 && log_op[0] == 2'd0, "R2 reset request first", 48'(log_op[0]), 48'd0);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R9 done seen", 48'(done), 48'd1);
    lat = cyc - last_bd; m = mac_addr; e = err_code;
    chk(m == exp_mac(), {"R7 R8 R3 mac ", name}, m, exp_mac());
    chk(e == exp_err(), {"R7 R8 R3 err ", name}, 48'(e), 48'(exp_err()));
    chk(lat == exp_lat(), {"R10 latency ", name}, 48'(lat), 48'(exp_lat()));
    if (dev_present) begin
      bit ok = (n_log == 34);
      ok &= (log_op[1] == 2'd1 && log_dat[1] == 8'hCC && log_op[2] == 2'd1 && log_dat[2] == 8'hF0);
      ok &= (log_op[3] == 2'd1 && log_dat[3] == 8'h00 && log_op[4] == 2'd1 && log_dat[4] == 8'h00);
      chk(ok, "R4 write sequence", 48'(n_log), 48'd34);
      ok = 1'b1;
      for (int i = 5; i < 34; i++) ok &= (log_op[i] == 2'd2);
      chk(ok, "R5 read count", 48'(n_log), 48'd34);
    end else
      chk(n_log == 1, "R3 no request after absence", 48'(n_log), 48'd1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", 48'(done), 48'd0);
    repeat (3) @(negedge clk);
    chk(!req_valid && mac_addr == m && err_code == e, "R2 R9 idle and held",
        mac_addr, m);
  endtask

  task automatic fill(bit match, int mis);
    for (int i = 0; i < 29; i++) dev[i] = 8'($urandom);
    if (match || mis >= 0) for (int k = 0; k < 16; k++) dev[12+k] = SIG[8*(15-k) +: 8];
    if (mis >= 0) dev[12+mis] = dev[12+mis] ^ 8'h01;
  endtask

  initial begin
    void'($urandom(32'd1234));
    noise = 0; start_at = -1; dev_present = 1;
    repeat (3) @(negedge clk);
    chk(!req_valid && !done && mac_addr == 0 && err_code == 0, "R1 reset state", mac_addr, 48'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_valid && !done && mac_addr == 0, "R1 idle after reset", mac_addr, 48'd0);

    dev_present = 0; fill(0, -1); run_fetch("absent");
    dev_present = 1; fill(1, -1); run_fetch("match");
    fill(0, 0); run_fetch("mismatch at 0");
    fill(0, 15); run_fetch("mismatch at 15");
    fill(0, -1); run_fetch("random bytes");
    noise = 1; start_at = 5; fill(1, -1); run_fetch("start with bus_done");
    start_at = 33; fill(0, 7); run_fetch("start on last read");
    start_at = 0; dev_present = 0; run_fetch("start on absent reply");
    dev_present = 1; start_at = -1;
    for (int t = 0; t < 20; t++) begin
      int mis;
      noise = bit'($urandom_range(0, 1));
      start_at = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 33) : -1;
      dev_present = ($urandom_range(0, 7) != 0);
      mis = ($urandom_range(0, 1) == 0) ? -1 : $urandom_range(0, 15);
      fill(mis < 0, mis);
      run_fetch("random run");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule